// File: doc/BRIEF.md
# Paired Instruction Fetch with Shared-Port Arbitration

This block is the fetch front end of a five-stage pipeline whose instructions are 16 bits wide. One 32-bit read of the memory port returns two instructions. The block passes them to decode one at a time over a valid/ready handshake. The first instruction of a word goes straight from the read data to decode. The second waits in a holding register until decode takes it.

The fetch logic shares one synchronous, single-ported memory with the memory-access stage. That stage issues loads, stores, control-register transfers from memory and multiply-accumulate operand reads. Under uninterrupted flow the fetch reads the port only in every second cycle, the leading slot, so a data access that falls in the other slot costs nothing. When a data access meets a leading slot, the data access takes the port and the fetch slips by one cycle. A stall flag and a running stall count report each such conflict. A redirect strobe restarts fetching at a branch target and discards anything already fetched.

Top module: `pair_fetch`

## Requirements
- R1: After reset, instruction valid is low, the stall count is zero, and the first fetch reads the reset vector in the first cycle after reset is released.
- R2: In the word read from 4-byte-aligned address A, bits [15:0] hold the instruction at A and bits [31:16] hold the instruction at A+2. Decode receives them in address order, A first.
- R3: While decode stays ready and no data access occurs, one instruction is delivered in every cycle and the fetch uses the port once every two cycles.
- R4: In any cycle with a data request, the port carries that request's address, write enable and write data.
- R5: A data request in a cycle where the fetch wants the port raises the stall flag in that cycle. It delays the instruction stream by exactly one cycle and raises the stall count by exactly one.
- R6: A data request in the slot where no fetch is due causes no stall flag, no change to the stall count and no lost delivery cycle.
- R7: Every fetch reads a 4-byte-aligned address, and successive fetches advance by 4 bytes.
- R8: In a redirect cycle instruction valid is low and held instructions are discarded. The next instruction delivered is the one at the target.
- R9: When the target is an odd halfword (address bit 1 set), only bits [31:16] of the first word are delivered. The next fetch follows without waiting a second cycle.
- R10: While decode is not ready, the presented instruction stays valid and unchanged, and no fetch is issued until the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_i | input | 1 | Branch redirect strobe |
| redirect_pc_i | input | AW | Redirect target byte address |
| ma_req_i | input | 1 | Data access request from the memory-access stage |
| ma_we_i | input | 1 | Data access is a write |
| ma_addr_i | input | AW | Data access address |
| ma_wdata_i | input | 32 | Data access write data |
| mem_en_o | output | 1 | Port access enable |
| mem_we_o | output | 1 | Port write enable |
| mem_addr_o | output | AW | Port address |
| mem_wdata_o | output | 32 | Port write data |
| mem_rdata_i | input | 32 | Port read data, one cycle after the access |
| ins_valid_o | output | 1 | Instruction valid to decode |
| ins_o | output | 16 | Instruction to decode |
| ins_ready_i | input | 1 | Decode can accept an instruction |
| fetch_stall_o | output | 1 | Fetch lost the port to a data access this cycle |
| stall_cnt_o | output | SCW | Number of stall cycles since reset |

## Verification
A fetch placed on the port in cycle c returns its first instruction at decode in cycle c+1 and its second in c+2. The next fetch goes out in c+2, so the stream is continuous. The stall flag is due in the same cycle as the conflicting data request, and the count includes that stall from the next edge on. A redirect drops valid in its own cycle, and the target instruction is due one cycle later unless a data access pushes it back. The bench drives inputs just after each rising edge and samples at the falling edge of the cycle in which a result is due. For each scenario, a per-cycle model of the leading slot computes which cycles stall and how many instructions fall inside the window. The bench compares the delivered stream, the stall flag in each cycle and the count difference against that model.

// File: rtl/pair_fetch.sv
module pair_fetch #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_VEC = '0,
  parameter int SCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           redirect_i,
  input  logic [AW-1:0]  redirect_pc_i,
  input  logic           ma_req_i,
  input  logic           ma_we_i,
  input  logic [AW-1:0]  ma_addr_i,
  input  logic [31:0]    ma_wdata_i,
  output logic           mem_en_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic [31:0]    mem_rdata_i,
  output logic           ins_valid_o,
  output logic [15:0]    ins_o,
  input  logic           ins_ready_i,
  output logic           fetch_stall_o,
  output logic [SCW-1:0] stall_cnt_o
);

  logic [AW-1:0]  pc_q;
  logic [31:0]    buf_q;
  logic [1:0]     hv_q;
  logic           rd_pend_q, pend_odd_q, odd_q;
  logic [SCW-1:0] cnt_q;

  wire        use_buf = |hv_q;
  wire [1:0]  arr_v   = pend_odd_q ? 2'b10 : 2'b11;
  wire [1:0]  cur_v   = use_buf ? hv_q : (rd_pend_q ? arr_v : 2'b00);
  wire [31:0] cur_w   = use_buf ? buf_q : mem_rdata_i;

  assign ins_valid_o = (|cur_v) && !redirect_i;
  assign ins_o       = cur_v[0] ? cur_w[15:0] : cur_w[31:16];

  wire       fire   = ins_valid_o && ins_ready_i;
  wire [1:0] lowbit = cur_v[0] ? 2'b01 : 2'b10;
  wire [1:0] hv_d   = redirect_i ? 2'b00 : (cur_v & ~(fire ? lowbit : 2'b00));

  wire          fetch_want = redirect_i || (hv_d == 2'b00);
  wire          fetch_go   = fetch_want && !ma_req_i;
  wire [AW-1:0] fetch_addr = redirect_i ? {redirect_pc_i[AW-1:2], 2'b00} : pc_q;

  assign fetch_stall_o = fetch_want && ma_req_i;
  assign stall_cnt_o   = cnt_q;

  assign mem_en_o    = ma_req_i || fetch_go;
  assign mem_we_o    = ma_req_i && ma_we_i;
  assign mem_addr_o  = ma_req_i ? ma_addr_i : fetch_addr;
  assign mem_wdata_o = ma_wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= {RESET_VEC[AW-1:2], 2'b00};
      buf_q      <= '0;
      hv_q       <= 2'b00;
      rd_pend_q  <= 1'b0;
      pend_odd_q <= 1'b0;
      odd_q      <= RESET_VEC[1];
      cnt_q      <= '0;
    end else begin
      hv_q      <= hv_d;
      rd_pend_q <= fetch_go;
      if (!use_buf && rd_pend_q) buf_q <= mem_rdata_i;
      if (fetch_go) begin
        pc_q       <= fetch_addr + AW'(4);
        pend_odd_q <= redirect_i ? redirect_pc_i[1] : odd_q;
        odd_q      <= 1'b0;
      end else if (redirect_i) begin
        pc_q  <= fetch_addr;
        odd_q <= redirect_pc_i[1];
      end
      if (fetch_stall_o) cnt_q <= cnt_q + SCW'(1);
    end
  end

  p_stall_needs_ma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall_o |-> ma_req_i);

  p_stall_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall_o |=> stall_cnt_o == $past(stall_cnt_o) + SCW'(1));

  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !ma_req_i) |-> mem_addr_o[1:0] == 2'b00);

  p_half_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !redirect_i && !odd_q) |=> (!fetch_go || redirect_i));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_o && !ins_ready_i && !redirect_i) |=> (redirect_i || (ins_valid_o && $stable(ins_o))));

  p_hold_no_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_o && !ins_ready_i && !redirect_i) |-> !fetch_go);

endmodule

// File: tb/sim_pair_fetch.sv
`timescale 1ns/1ps
module sim_pair_fetch;
  localparam int AW = 32;
  localparam logic [31:0] RV = 32'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic redirect = 1'b0, ma_req = 1'b0, ma_we = 1'b0, ready = 1'b0;
  logic [31:0] rpc = '0, ma_addr = '0, ma_wdata = '0;
  logic mem_en, mem_we, ins_valid, fetch_stall;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic [15:0] ins, stall_cnt, mon_e;

  pair_fetch #(.AW(AW), .RESET_VEC(RV), .SCW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect), .redirect_pc_i(rpc),
    .ma_req_i(ma_req), .ma_we_i(ma_we), .ma_addr_i(ma_addr), .ma_wdata_i(ma_wdata),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata), .ins_valid_o(ins_valid), .ins_o(ins), .ins_ready_i(ready),
    .fetch_stall_o(fetch_stall), .stall_cnt_o(stall_cnt));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] ins_at(input logic [31:0] a);
    return a[16:1] ^ 16'h5A00;
  endfunction

  initial rdata = '0;
  always @(posedge clk)
    if (mem_en && !mem_we) rdata <= {ins_at(mem_addr + 32'd2), ins_at(mem_addr)};

  int errs = 0, checks = 0, ndeliv = 0;
  logic [15:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (ins_valid && ready) begin
      ndeliv++;
      if (exp_q.size() == 0) check(1'b0, "R2", "unexpected instruction", ins, 0);
      else begin
        mon_e = exp_q.pop_front();
        check(ins == mon_e, "R2", "instruction order", ins, mon_e);
      end
    end
    if (ma_req)
      check(mem_en && mem_we == ma_we && mem_addr == ma_addr && mem_wdata == ma_wdata,
            "R4", "data access owns port", mem_addr, ma_addr);
    if (mem_en && !ma_req)
      check(mem_addr[1:0] == 2'b00, "R7", "fetch alignment", mem_addr, 0);
  end

  task automatic drive_ma(input bit on, input int c);
    ma_req   = on;
    ma_we    = c[0];
    ma_addr  = 32'h8000 + 32'(4 * c);
    ma_wdata = 32'hC0DE0000 + 32'(c);
  endtask

  // Entered just after a rising edge; cycle 0 is the redirect cycle.
  task automatic run(input logic [31:0] tgt, input logic [31:0] mam, input int n, input string req);
    int L = 0; bit first = 1'b1; int dl = 0; int st = 0;
    logic [31:0] stexp = '0; int d0; int s0;
    for (int c = 0; c <= n; c++) begin
      if (c == L) begin
        if (mam[c]) begin st++; stexp[c] = 1'b1; L++; end
        else begin
          int k;
          k = (first && tgt[1]) ? 1 : 2;
          for (int j = 1; j <= k; j++) if (c + j <= n) dl++;
          L = c + k; first = 1'b0;
        end
      end
    end
    for (int i = 0; i < dl; i++) exp_q.push_back(ins_at(tgt + 32'(2 * i)));
    d0 = ndeliv; s0 = int'(stall_cnt);
    redirect = 1'b1; rpc = tgt; ready = 1'b1; drive_ma(mam[0], 0);
    @(negedge clk);
    check(!ins_valid, "R8", "valid low in redirect cycle", ins_valid, 0);
    check(fetch_stall == stexp[0], req, "stall flag cycle 0", fetch_stall, stexp[0]);
    for (int c = 1; c <= n; c++) begin
      @(posedge clk); #1;
      redirect = 1'b0; drive_ma(mam[c], c);
      @(negedge clk);
      check(fetch_stall == stexp[c], req, "stall flag", fetch_stall, stexp[c]);
    end
    @(posedge clk); #1;
    ma_req = 1'b0;
    check(ndeliv - d0 == dl, req, "deliveries in window", ndeliv - d0, dl);
    check(int'(stall_cnt) - s0 == st, req, "stall count delta", int'(stall_cnt) - s0, st);
    check(exp_q.size() == 0, "R8", "stream complete before redirect", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!ins_valid, "R1", "valid after reset", ins_valid, 0);
    check(stall_cnt == 0, "R1", "stall count after reset", stall_cnt, 0);
    check(mem_en && mem_addr == RV, "R1", "first fetch at reset vector", mem_addr, RV);
    @(posedge clk); #1;
    @(negedge clk);
    check(ins_valid && ins == ins_at(RV), "R2", "first of pair", ins, ins_at(RV));
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      @(negedge clk);
      check(ins_valid && ins == ins_at(RV), "R10", "held while not ready", ins, ins_at(RV));
      check(!mem_en, "R10", "no fetch while holding", mem_en, 0);
    end
    exp_q.push_back(ins_at(RV));
    exp_q.push_back(ins_at(RV + 32'd2));
    exp_q.push_back(ins_at(RV + 32'd4));
    @(posedge clk); #1 ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(ndeliv == 3, "R3", "release after hold", ndeliv, 3);

    run(32'h100, 32'h0, 12, "R3");
    run(32'h200, 32'h4, 12, "R5");
    run(32'h300, 32'hA, 12, "R6");
    run(32'h402, 32'h0, 9, "R9");
    run(32'h502, 32'h2, 9, "R9");
    run(32'h600, 32'h55, 14, "R5");
    run(32'h700, 32'h3E, 12, "R5");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule